// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the six condition and mode bits of an 8-bit accumulator CPU: negative, overflow, decimal, interrupt mask, zero and carry. Each cycle that the enable is high, the core's sequencer presents one operation class. The block then updates the bits that class owns and leaves all the others alone. The values it takes in come from the ALU result, the ALU carry and overflow outputs, the bit a shift pushed out, the operand of a bit-test, and a byte read back from the stack.

Two bits of the 8-bit status image have no storage. When the flags are saved, the image carries a constant 1 in bit 5 and a cause bit in bit 4. The cause bit is high for instruction-driven saves and low for hardware interrupt entry. When the flags are restored, those two bits are dropped. Decimal arithmetic sits outside this block, but the decimal bit is stored and can be read back like the others.

Top module: `cpu_status_reg`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and after it is released, the interrupt mask is 1 and the other five flags are 0. With the cause input high, push_byte reads 0x34.
- R2: push_byte is combinational from the current flags. Bit 7 is N, bit 6 is V, bit 5 is constant 1, bit 4 equals push_is_insn, bit 3 is D, bit 2 is I, bit 1 is Z and bit 0 is C. The flag_* outputs carry the same six values.
- R3: Class 13 (restore) loads N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 of pull_byte. Bits 5 and 4 of pull_byte have no effect.
- R4: Class 1 (add or subtract) sets C to alu_carry and V to alu_ovf. It sets N to the result MSB and Z to 1 when the result is all zero. D and I are unchanged.
- R5: Class 2 (compare) writes C from alu_carry, which is high when no borrow occurs. It writes N and Z from the result. V is unchanged.
- R6: Class 3 (shift or rotate) writes C from shift_out and writes N and Z from the result. V is unchanged.
- R7: Class 4 (value-producing: load, logic, increment, decrement) writes only N and Z from the result. C and V are unchanged.
- R8: Class 5 (bit test) copies bit_operand bit 7 into N and bit 6 into V. It sets Z when the result is zero. C is unchanged.
- R9: Classes 6 and 7 set and clear C, classes 8 and 9 set and clear I, and classes 10 and 11 set and clear D. Each touches only its own flag.
- R10: Class 12 clears V. V can only become 1 through class 1, class 5 or class 13.
- R11: With op_en low, or with class 0, 14 or 15, no flag changes, whatever the other inputs carry.
- R12: Flags are registered. A class applied with op_en high shows on the outputs after the next rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_en | input | 1 | Apply op_class this cycle |
| op_class | input | 4 | Operation class code |
| alu_result | input | DATA_W | Result value for N and Z |
| alu_carry | input | 1 | ALU carry-out, or no-borrow for subtract and compare |
| alu_ovf | input | 1 | ALU signed overflow |
| shift_out | input | 1 | Bit shifted out by a shift or rotate |
| bit_operand | input | DATA_W | Memory operand of a bit test |
| pull_byte | input | 8 | Status image read from the stack |
| push_is_insn | input | 1 | Save cause: 1 for an instruction, 0 for an interrupt |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_d | output | 1 | Decimal mode |
| flag_i | output | 1 | Interrupt mask |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |
| push_byte | output | 8 | Status image to save |

## Verification
The assertions assume that the enable and the class code are settled before each rising edge, and that the ALU side inputs belong to the same cycle as the class they go with. They also assume that codes 14 and 15 may arrive and must do nothing. The bench drives every input on the falling edge, holds it for a full cycle and samples on the following falling edge. It therefore never changes a value near the edge where the flags are captured. On the reserved and disabled cycles it deliberately puts conflicting values on the side inputs, so that any leak into the flags would show up in the saved image.

// File: rtl/flag_pkg.sv
package flag_pkg;

  // Width of the saved or restored status image; the bit layout is fixed.
  localparam int STAT_W = 8;

  // Bit positions inside the status image
  localparam int BP_N   = 7;
  localparam int BP_V   = 6;
  localparam int BP_ONE = 5;
  localparam int BP_B   = 4;
  localparam int BP_D   = 3;
  localparam int BP_I   = 2;
  localparam int BP_Z   = 1;
  localparam int BP_C   = 0;

  typedef enum logic [3:0] {
    OPC_HOLD   = 4'd0,
    OPC_ADDSUB = 4'd1,
    OPC_CMP    = 4'd2,
    OPC_SHIFT  = 4'd3,
    OPC_VALUE  = 4'd4,
    OPC_BIT    = 4'd5,
    OPC_SET_C  = 4'd6,
    OPC_CLR_C  = 4'd7,
    OPC_SET_I  = 4'd8,
    OPC_CLR_I  = 4'd9,
    OPC_SET_D  = 4'd10,
    OPC_CLR_D  = 4'd11,
    OPC_CLR_V  = 4'd12,
    OPC_PULL   = 4'd13
  } op_class_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  localparam flags_t FLAGS_RST = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};

  // Status image built from stored flags and the save cause
  function automatic logic [STAT_W-1:0] pack_image(input flags_t f, input logic insn_cause);
    logic [STAT_W-1:0] img;
    img         = '0;
    img[BP_N]   = f.n;
    img[BP_V]   = f.v;
    img[BP_ONE] = 1'b1;
    img[BP_B]   = insn_cause;
    img[BP_D]   = f.d;
    img[BP_I]   = f.i;
    img[BP_Z]   = f.z;
    img[BP_C]   = f.c;
    return img;
  endfunction

  // Stored flags recovered from a status image; bits 5 and 4 are dropped
  function automatic flags_t unpack_image(input logic [STAT_W-1:0] img);
    flags_t f;
    f.n = img[BP_N];
    f.v = img[BP_V];
    f.d = img[BP_D];
    f.i = img[BP_I];
    f.z = img[BP_Z];
    f.c = img[BP_C];
    return f;
  endfunction

endpackage

// File: rtl/flag_nz_eval.sv
module flag_nz_eval #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] value_i,
  output logic              neg_o,
  output logic              zero_o
);
  localparam int MSB = DATA_W - 1;

  assign neg_o  = value_i[MSB];
  assign zero_o = (value_i == '0);
endmodule

// File: rtl/flag_byte_io.sv
module flag_byte_io
  import flag_pkg::*;
(
  input  flags_t              cur_i,
  input  logic                insn_cause_i,
  input  logic [STAT_W-1:0]   pull_byte_i,
  output logic [STAT_W-1:0]   push_byte_o,
  output flags_t              pulled_o
);
  assign push_byte_o = pack_image(cur_i, insn_cause_i);
  assign pulled_o    = unpack_image(pull_byte_i);
endmodule

// File: rtl/flag_next_sel.sv
module flag_next_sel
  import flag_pkg::*;
(
  input  flags_t    cur_i,
  input  logic      en_i,
  input  op_class_e op_i,
  input  logic      res_neg_i,
  input  logic      res_zero_i,
  input  logic      alu_carry_i,
  input  logic      alu_ovf_i,
  input  logic      shift_out_i,
  input  logic      bit_n_i,
  input  logic      bit_v_i,
  input  flags_t    pulled_i,
  output flags_t    next_o,
  output logic      upd_nz_o,
  output logic      upd_c_o,
  output logic      upd_v_o
);
  always_comb begin
    next_o   = cur_i;
    upd_nz_o = 1'b0;
    upd_c_o  = 1'b0;
    upd_v_o  = 1'b0;
    if (en_i) begin
      case (op_i)
        OPC_ADDSUB: begin
          next_o.n = res_neg_i;
          next_o.z = res_zero_i;
          next_o.c = alu_carry_i;
          next_o.v = alu_ovf_i;
          upd_nz_o = 1'b1;
          upd_c_o  = 1'b1;
          upd_v_o  = 1'b1;
        end
        OPC_CMP: begin
          next_o.n = res_neg_i;
          next_o.z = res_zero_i;
          next_o.c = alu_carry_i;
          upd_nz_o = 1'b1;
          upd_c_o  = 1'b1;
        end
        OPC_SHIFT: begin
          next_o.n = res_neg_i;
          next_o.z = res_zero_i;
          next_o.c = shift_out_i;
          upd_nz_o = 1'b1;
          upd_c_o  = 1'b1;
        end
        OPC_VALUE: begin
          next_o.n = res_neg_i;
          next_o.z = res_zero_i;
          upd_nz_o = 1'b1;
        end
        OPC_BIT: begin
          next_o.n = bit_n_i;
          next_o.v = bit_v_i;
          next_o.z = res_zero_i;
          upd_nz_o = 1'b1;
          upd_v_o  = 1'b1;
        end
        OPC_SET_C: begin next_o.c = 1'b1; upd_c_o = 1'b1; end
        OPC_CLR_C: begin next_o.c = 1'b0; upd_c_o = 1'b1; end
        OPC_SET_I: next_o.i = 1'b1;
        OPC_CLR_I: next_o.i = 1'b0;
        OPC_SET_D: next_o.d = 1'b1;
        OPC_CLR_D: next_o.d = 1'b0;
        OPC_CLR_V: begin next_o.v = 1'b0; upd_v_o = 1'b1; end
        OPC_PULL: begin
          next_o   = pulled_i;
          upd_nz_o = 1'b1;
          upd_c_o  = 1'b1;
          upd_v_o  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [3:0]        op_class,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              shift_out,
  input  logic [DATA_W-1:0] bit_operand,
  input  logic [STAT_W-1:0] pull_byte,
  input  logic              push_is_insn,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_d,
  output logic              flag_i,
  output logic              flag_z,
  output logic              flag_c,
  output logic [STAT_W-1:0] push_byte
);
  localparam int BIT_N_POS = DATA_W - 1;
  localparam int BIT_V_POS = DATA_W - 2;

  op_class_e op_e;
  flags_t    flags_q;
  flags_t    flags_d;
  flags_t    pulled;
  logic      res_neg;
  logic      res_zero;
  logic      upd_nz;
  logic      upd_c;
  logic      upd_v;

  assign op_e = op_class_e'(op_class);

  flag_nz_eval #(.DATA_W(DATA_W)) nz_i (
    .value_i (alu_result),
    .neg_o   (res_neg),
    .zero_o  (res_zero)
  );

  flag_byte_io io_i (
    .cur_i        (flags_q),
    .insn_cause_i (push_is_insn),
    .pull_byte_i  (pull_byte),
    .push_byte_o  (push_byte),
    .pulled_o     (pulled)
  );

  flag_next_sel sel_i (
    .cur_i       (flags_q),
    .en_i        (op_en),
    .op_i        (op_e),
    .res_neg_i   (res_neg),
    .res_zero_i  (res_zero),
    .alu_carry_i (alu_carry),
    .alu_ovf_i   (alu_ovf),
    .shift_out_i (shift_out),
    .bit_n_i     (bit_operand[BIT_N_POS]),
    .bit_v_i     (bit_operand[BIT_V_POS]),
    .pulled_i    (pulled),
    .next_o      (flags_d),
    .upd_nz_o    (upd_nz),
    .upd_c_o     (upd_c),
    .upd_v_o     (upd_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RST;
    else        flags_q <= flags_d;
  end

  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;
  assign flag_d = flags_q.d;
  assign flag_i = flags_q.i;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;

  // R11: an idle cycle leaves every flag where it was
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(flags_q));

  // R7: carry moves only in cycles that select a carry writer
  a_r7_c_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_c |=> $stable(flag_c));

  // R10: overflow moves only in cycles that select an overflow writer
  a_r10_v_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_v |=> $stable(flag_v));

  // R7: N and Z move only for result-bearing, bit-test or restore classes
  a_r7_nz_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_nz |=> $stable({flag_n, flag_z}));

  // R10: overflow can only rise after add/subtract, bit test or restore
  a_r10_v_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_v) |-> $past(op_en && (op_e == OPC_ADDSUB || op_e == OPC_BIT || op_e == OPC_PULL)));

  // R10: the clear command leaves overflow low
  a_r10_clear_v: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_e == OPC_CLR_V) |=> !flag_v);

  // R8: bit test copies operand's top two bits
  a_r8_bit_copies_nv: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_e == OPC_BIT) |=>
      (flag_n == $past(bit_operand[BIT_N_POS]) && flag_v == $past(bit_operand[BIT_V_POS])));

  // R6: shift places the shifted-out bit in carry
  a_r6_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_e == OPC_SHIFT) |=> flag_c == $past(shift_out));

  // R3: a restored image comes back out of the saved image unchanged except bits 5 and 4
  a_r3_restore_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_e == OPC_PULL) |=>
      (push_byte[7:6] == $past(pull_byte[7:6]) && push_byte[3:0] == $past(pull_byte[3:0])));

endmodule

// File: tb/cpu_status_reg_tb_top.sv
module cpu_status_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_en;
  logic [3:0] op_class;
  logic [7:0] alu_result;
  logic       alu_carry;
  logic       alu_ovf;
  logic       shift_out;
  logic [7:0] bit_operand;
  logic [7:0] pull_byte;
  logic       push_is_insn;
  logic       flag_n, flag_v, flag_d, flag_i, flag_z, flag_c;
  logic [7:0] push_byte;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cpu_status_reg #(.DATA_W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_en        (op_en),
    .op_class     (op_class),
    .alu_result   (alu_result),
    .alu_carry    (alu_carry),
    .alu_ovf      (alu_ovf),
    .shift_out    (shift_out),
    .bit_operand  (bit_operand),
    .pull_byte    (pull_byte),
    .push_is_insn (push_is_insn),
    .flag_n       (flag_n),
    .flag_v       (flag_v),
    .flag_d       (flag_d),
    .flag_i       (flag_i),
    .flag_z       (flag_z),
    .flag_c       (flag_c),
    .push_byte    (push_byte)
  );

  // {class, result, carry, ovf, shift_out, bit_operand, pull_byte, expected image with cause=1}
  localparam int NVEC = 23;
  localparam logic [38:0] VEC [NVEC] = '{
    {4'd1,  8'h80, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hB4}, // R4 negative, no carry
    {4'd2,  8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h37}, // R5 equal, V untouched
    {4'd3,  8'h40, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h34}, // R6 carry from shift_out
    {4'd3,  8'hFE, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'hB5}, // R6
    {4'd4,  8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h37}, // R7 C and V kept
    {4'd5,  8'h00, 1'b0, 1'b0, 1'b0, 8'hC0, 8'h00, 8'hF7}, // R8
    {4'd12, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hB7}, // R10 clear V
    {4'd9,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hB3}, // R9 clear I
    {4'd10, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hBB}, // R9 set D
    {4'd7,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hBA}, // R9 clear C
    {4'd0,  8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hBA}, // R11 class 0
    {4'd14, 8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hBA}, // R11 reserved
    {4'd15, 8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hBA}, // R11 reserved
    {4'd5,  8'h12, 1'b1, 1'b0, 1'b1, 8'h40, 8'h00, 8'h78}, // R8 V only
    {4'd13, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h30}, // R3 all clear
    {4'd13, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'hCF, 8'hFF}, // R3 all set, 5/4 low
    {4'd13, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h30, 8'h30}, // R3 5/4 ignored
    {4'd6,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h31}, // R9 set C
    {4'd8,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h35}, // R9 set I
    {4'd10, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h3D}, // R9 set D
    {4'd11, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h35}, // R9 clear D
    {4'd2,  8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h34}, // R5 borrow
    {4'd6,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h35}  // R9 set C
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1:  return "R4";
      4'd2:  return "R5";
      4'd3:  return "R6";
      4'd4:  return "R7";
      4'd5:  return "R8";
      4'd12: return "R10";
      4'd13: return "R3";
      4'd0, 4'd14, 4'd15: return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL R12: watchdog expired, actual hang expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_en = 1'b0; op_class = 4'd0; alu_result = 8'h00;
    alu_carry = 1'b0; alu_ovf = 1'b0; shift_out = 1'b0; bit_operand = 8'h00;
    pull_byte = 8'h00; push_is_insn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", push_byte, 8'h34);
    push_is_insn = 1'b0; #1;
    chk("R2", push_byte, 8'h24);
    push_is_insn = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", push_byte, 8'h34);
    chk("R1", {2'b00, flag_n, flag_v, flag_d, flag_i, flag_z, flag_c}, 8'h04);

    // R12: nothing visible before the capturing edge
    op_class = 4'd1; alu_result = 8'h00; alu_carry = 1'b1; alu_ovf = 1'b1; op_en = 1'b1;
    #1;
    chk("R12", push_byte, 8'h34);
    @(negedge clk);
    op_en = 1'b0;
    chk("R4", push_byte, 8'h77);

    for (int k = 0; k < NVEC; k++) begin
      op_class    = VEC[k][38:35];
      alu_result  = VEC[k][34:27];
      alu_carry   = VEC[k][26];
      alu_ovf     = VEC[k][25];
      shift_out   = VEC[k][24];
      bit_operand = VEC[k][23:16];
      pull_byte   = VEC[k][15:8];
      op_en       = 1'b1;
      @(negedge clk);
      op_en = 1'b0;
      chk(req_of(VEC[k][38:35]), push_byte, VEC[k][7:0]);
    end

    // R2: interrupt cause clears bit 4; flag pins match the image
    push_is_insn = 1'b0; #1;
    chk("R2", push_byte, 8'h25);
    chk("R2", {2'b00, flag_n, flag_v, flag_d, flag_i, flag_z, flag_c}, 8'h05);
    push_is_insn = 1'b1;

    // R11: enable low with an active class and loud side inputs
    op_class = 4'd13; pull_byte = 8'hCA; alu_result = 8'h80; alu_ovf = 1'b1; op_en = 1'b0;
    @(negedge clk);
    chk("R11", push_byte, 8'h35);

    // R1: reset in mid-run returns to the reset image at once
    rst_n = 1'b0; #1;
    chk("R1", push_byte, 8'h34);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", push_byte, 8'h34);

    finish_run();
  end

endmodule